// File: doc/BRIEF.md
# Cascadable Gated Toggle Timer

A timer channel built to sit in a chain of identical channels. A programmable prescaler divides the system clock into count ticks. A counter advances on each tick and wraps back to zero after reaching a programmable period. Each time the counter passes a programmable compare value, a square-wave output inverts. The output frequency is therefore tick_rate / (2 x (period + 1)).

The counter is gated. It runs only while a master run bit is set and a selected trigger is active. The trigger can be an external pin, synchronized and with selectable active level, or one of several internal trigger lines. While the gate is inactive, both the counter and the prescaler hold their values.

The block exports its registered counter-enable state as a trigger output. Feeding that output into the internal trigger line of the next instance builds a cascade: an external signal gates the first stage, the first stage gates the second, and so on.

Top module: `gated_toggle_timer`

## Requirements
- R1: Reset (synchronous, active high) clears `count_out`, `wave_out` and `trig_out` to 0, along with the prescaler count.
- R2: While enabled, the counter advances once every `presc_val`+1 enabled clock cycles. The prescaler holds its partial count while disabled, so split bursts of enabled cycles add up exactly.
- R3: On a tick where the counter equals `period_val`, the counter returns to 0. On any other tick it increments by one.
- R4: `wave_out` inverts on each tick where the counter, before the tick, equals `compare_val`. After T ticks, the number of inversions is 0 if T <= compare, and otherwise ((T-1-compare) div (period+1)) + 1.
- R5: The counter and `wave_out` hold their values while the gate is inactive.
- R6: `trig_out` is the internal enable, registered as `run_en` AND gate. It rises or falls one clock edge after the gate or `run_en` changes, and the counter advances only on edges where `trig_out` was already 1.
- R7: `trig_sel` picks the gate source:
  - 0 selects the external pin.
  - A value k from 1 to N_ITR selects `itr_in[k-1]`.
  - Any larger value makes the gate permanently inactive.
- R8: The external pin passes through a two-flop synchronizer. The pin is active high when `ext_pol`=0 and active low when `ext_pol`=1. `trig_out` follows a pin change on the third clock edge after it.
- R9: With `run_en`=0, `trig_out` stays 0 and the counter holds, whatever the gate does.
- R10: In a cascade, a stage fed by the upstream `trig_out` raises its own `trig_out` one edge after the upstream one. With equal settings, once the chain settles it holds the same count as the upstream stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Master run bit |
| trig_sel | input | SEL_W | Gate source select |
| ext_pin | input | 1 | Asynchronous external gate pin |
| ext_pol | input | 1 | External pin active level (0 high, 1 low) |
| itr_in | input | N_ITR | Internal trigger lines from other stages |
| presc_val | input | PRE_W | Prescaler value P (divide by P+1) |
| period_val | input | CNT_W | Counter wrap value |
| compare_val | input | CNT_W | Toggle compare value |
| trig_out | output | 1 | Registered counter-enable state |
| wave_out | output | 1 | Toggle waveform |
| count_out | output | CNT_W | Current counter value |

## Verification
Two kinds of prescaler fault look different at the ports. If the prescaler state is lost or advanced across a gate transition, `count_out` after split bursts falls short of, or runs ahead of, what the total of enabled cycles predicts; this shows at the first tick after the second burst. If the synchronizer depth is wrong, `trig_out` rises an edge too early or too late after a pin change, which is visible within three clock cycles.

A wrong compare or wrap state shows as a `count_out` that does not return to zero after period+1 ticks, or as a `wave_out` level with the wrong parity against the tick count. In a chain, a fault in a stage's gate path appears as a count mismatch against the stage above it once the chain has settled.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  // trigger select code reserved for the external pin
  localparam int unsigned SEL_EXT = 0;
endpackage

// File: rtl/gtt_gate_sel.sv
module gtt_gate_sel #(
  parameter int N_ITR = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             pol,
  input  logic [N_ITR-1:0] itr,
  input  logic [SEL_W-1:0] sel,
  output logic             gate
);
  import gtt_pkg::*;

  logic meta_q, sync_q;

  // two-flop synchronizer for the asynchronous pin (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
    end
  end

  // source mux; out-of-range codes give an inactive gate (R7)
  always_comb begin
    gate = 1'b0;
    if (sel == SEL_W'(SEL_EXT)) gate = sync_q ^ pol;
    for (int k = 0; k < N_ITR; k++)
      if (sel == SEL_W'(k + 1)) gate = itr[k];
  end

  p_sync_two_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gtt_prescaler.sv
module gtt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q;

  assign tick = en && (pc_q == div_val);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (tick) pc_q <= '0;
    else if (en)   pc_q <= pc_q + 1'b1;
  end

  // partial count frozen while gated off (R2)
  p_pre_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_q));
endmodule

// File: rtl/gtt_counter.sv
module gtt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             wave
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      cnt <= (cnt == period) ? '0 : cnt + 1'b1;
      if (cnt == cmp) wave <= ~wave;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && $stable(wave)));
  p_wave_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(wave) |-> $past(tick));
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == period) |=> (cnt == '0));
endmodule

// File: rtl/gated_toggle_timer.sv
module gated_toggle_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int N_ITR = 2,
  localparam int SEL_W = $clog2(N_ITR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             ext_pin,
  input  logic             ext_pol,
  input  logic [N_ITR-1:0] itr_in,
  input  logic [PRE_W-1:0] presc_val,
  input  logic [CNT_W-1:0] period_val,
  input  logic [CNT_W-1:0] compare_val,
  output logic             trig_out,
  output logic             wave_out,
  output logic [CNT_W-1:0] count_out
);
  logic gate, en_q, tick;

  gtt_gate_sel #(.N_ITR(N_ITR), .SEL_W(SEL_W)) u_gate (
    .clk(clk), .rst(rst), .pin(ext_pin), .pol(ext_pol),
    .itr(itr_in), .sel(trig_sel), .gate(gate)
  );

  // registered enable, exported as the trigger for the next stage (R6)
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= run_en & gate;
  end
  assign trig_out = en_q;

  gtt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en_q), .div_val(presc_val), .tick(tick)
  );

  gtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .period(period_val),
    .cmp(compare_val), .cnt(count_out), .wave(wave_out)
  );

  p_runen_low_r9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !trig_out);
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !trig_out |=> $stable(count_out));
endmodule

// File: tb/gated_toggle_timer_tb.sv
module gated_toggle_timer_tb;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int NI = 2;
  localparam int SW = $clog2(NI + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [SW-1:0] trig_sel = '0;
  logic ext_pin = 1'b0;
  logic ext_pol = 1'b0;
  logic [NI-1:0] itr_in = '0;
  logic [PW-1:0] presc_val = '0;
  logic [CW-1:0] period_val = '0;
  logic [CW-1:0] compare_val = '0;
  logic trig_out, wave_out;
  logic [CW-1:0] count_out;
  logic t1, w1, t2, w2;
  logic [CW-1:0] c1, c2;

  int checks = 0;
  int fails = 0;
  int tot = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_toggle_timer #(.CNT_W(CW), .PRE_W(PW), .N_ITR(NI)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .trig_sel(trig_sel),
    .ext_pin(ext_pin), .ext_pol(ext_pol), .itr_in(itr_in),
    .presc_val(presc_val), .period_val(period_val), .compare_val(compare_val),
    .trig_out(trig_out), .wave_out(wave_out), .count_out(count_out)
  );

  // cascade stages for R10, each gated by the stage above through itr_in[0]
  gated_toggle_timer #(.CNT_W(CW), .PRE_W(PW), .N_ITR(NI)) u_st2 (
    .clk(clk), .rst(rst), .run_en(1'b1), .trig_sel(SW'(1)),
    .ext_pin(1'b0), .ext_pol(1'b0), .itr_in({1'b0, trig_out}),
    .presc_val(presc_val), .period_val(period_val), .compare_val(compare_val),
    .trig_out(t1), .wave_out(w1), .count_out(c1)
  );
  gated_toggle_timer #(.CNT_W(CW), .PRE_W(PW), .N_ITR(NI)) u_st3 (
    .clk(clk), .rst(rst), .run_en(1'b1), .trig_sel(SW'(1)),
    .ext_pin(1'b0), .ext_pol(1'b0), .itr_in({1'b0, t1}),
    .presc_val(presc_val), .period_val(period_val), .compare_val(compare_val),
    .trig_out(t2), .wave_out(w2), .count_out(c2)
  );

  function automatic int exp_cnt(int n);
    return (n / (int'(presc_val) + 1)) % (int'(period_val) + 1);
  endfunction

  function automatic int exp_wave(int n);
    int t = n / (int'(presc_val) + 1);
    if (t <= int'(compare_val)) return 0;
    return (((t - 1 - int'(compare_val)) / (int'(period_val) + 1)) + 1) % 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(string req);
    chk(req, int'(count_out), exp_cnt(tot));
    chk(req, int'(wave_out), exp_wave(tot));
  endtask

  task automatic do_reset(int p, int per, int cmp);
    @(negedge clk);
    rst = 1'b1; run_en = 1'b0; itr_in = '0; ext_pin = 1'b0; ext_pol = 1'b0;
    trig_sel = SW'(1);
    presc_val = PW'(p); period_val = CW'(per); compare_val = CW'(cmp);
    edges(3);
    rst = 1'b0; tot = 0;
    edges(1);
  endtask

  // one burst of n enabled edges through itr_in[idx]
  task automatic itr_burst(int idx, int n);
    itr_in[idx] = 1'b1;
    edges(n);
    itr_in[idx] = 1'b0;
    edges(4);
    tot += n;
  endtask

  task automatic t_reset_r1();
    do_reset(2, 4, 1);
    chk("R1 count", int'(count_out), 0);
    chk("R1 wave", int'(wave_out), 0);
    chk("R1 trig", int'(trig_out), 0);
  endtask

  task automatic t_prescale_wrap_r2_r3();
    do_reset(2, 4, 1);
    run_en = 1'b1;
    itr_burst(0, 7);  check_state("R2 first burst");
    itr_burst(0, 2);  check_state("R2 split burst keeps partial tick");
    itr_burst(0, 9);  check_state("R3 wrap past period");
  endtask

  task automatic t_hold_r5();
    int c = int'(count_out);
    edges(6);
    chk("R5 hold while gate off", int'(count_out), c);
    chk("R5 wave hold", int'(wave_out), exp_wave(tot));
  endtask

  task automatic t_toggle_r4();
    do_reset(0, 2, 2);
    run_en = 1'b1;
    itr_burst(0, 5);  check_state("R4 toggle after 5 ticks");
    itr_burst(0, 7);  check_state("R4 toggle after 12 ticks");
    itr_burst(0, 1);  check_state("R4 toggle after 13 ticks");
  endtask

  task automatic t_trig_timing_r6();
    itr_in[0] = 1'b1;
    chk("R6 trig not yet", int'(trig_out), 0);
    edges(1);
    chk("R6 trig one edge later", int'(trig_out), 1);
    itr_in[0] = 1'b0;
    edges(1);
    chk("R6 trig falls one edge later", int'(trig_out), 0);
    edges(3);
    tot += 1;
    check_state("R6 counted enabled edges");
  endtask

  task automatic t_select_r7();
    trig_sel = SW'(2);
    itr_in[0] = 1'b1;
    edges(5);
    itr_in[0] = 1'b0;
    edges(2);
    check_state("R7 sel 2 ignores itr0");
    itr_burst(1, 4);
    check_state("R7 sel 2 uses itr1");
    trig_sel = SW'(3);
    itr_in = '1; ext_pin = 1'b1;
    edges(6);
    chk("R7 invalid sel trig", int'(trig_out), 0);
    check_state("R7 invalid sel holds");
    itr_in = '0; ext_pin = 1'b0;
    edges(4);
    trig_sel = SW'(1);
  endtask

  task automatic t_ext_r8();
    do_reset(1, 5, 0);
    trig_sel = SW'(0);
    run_en = 1'b1;
    ext_pin = 1'b1;
    edges(2);
    chk("R8 sync not yet through", int'(trig_out), 0);
    edges(1);
    chk("R8 trig on third edge", int'(trig_out), 1);
    edges(6);
    ext_pin = 1'b0;
    edges(6);
    tot += 9;
    check_state("R8 active-high pin");
    run_en = 1'b0;
    ext_pol = 1'b1; ext_pin = 1'b1;
    edges(4);
    run_en = 1'b1;
    edges(4);
    chk("R8 low polarity, pin high inactive", int'(trig_out), 0);
    ext_pin = 1'b0;
    edges(5);
    ext_pin = 1'b1;
    edges(6);
    tot += 5;
    check_state("R8 active-low pin");
  endtask

  task automatic t_runen_r9();
    do_reset(1, 6, 2);
    itr_in[0] = 1'b1;
    edges(6);
    chk("R9 trig low without run_en", int'(trig_out), 0);
    chk("R9 count held", int'(count_out), 0);
    run_en = 1'b1;
    edges(7);
    run_en = 1'b0;
    edges(4);
    tot += 7;
    check_state("R9 run_en burst");
    itr_in[0] = 1'b0;
    edges(2);
  endtask

  task automatic t_chain_r10();
    do_reset(1, 3, 1);
    run_en = 1'b1;
    itr_in[0] = 1'b1;
    edges(1);
    chk("R10 stage1 trig", int'(trig_out), 1);
    chk("R10 stage2 not yet", int'(t1), 0);
    edges(1);
    chk("R10 stage2 trig", int'(t1), 1);
    chk("R10 stage3 not yet", int'(t2), 0);
    edges(1);
    chk("R10 stage3 trig", int'(t2), 1);
    edges(8);
    itr_in[0] = 1'b0;
    edges(5);
    tot += 11;
    check_state("R10 stage1 count");
    chk("R10 stage2 count", int'(c1), exp_cnt(tot));
    chk("R10 stage3 count", int'(c2), exp_cnt(tot));
    chk("R10 stage3 wave", int'(w2), exp_wave(tot));
  endtask

  initial begin
    t_reset_r1();
    t_prescale_wrap_r2_r3();
    t_hold_r5();
    t_trig_timing_r6();
    t_select_r7();
    t_toggle_r4();
    t_ext_r8();
    t_runen_r9();
    t_chain_r10();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule